// File: doc/BRIEF.md
# Planar Graphics Write and Read Datapath

This block sits between a host port and four parallel display planes of a planar frame buffer. For each host write it produces four bytes, one per plane, to be stored at the addressed location. The host byte can be rotated and combined with a stored per-plane latch value. It can also be replaced by per-plane fill values or spread across the planes one bit per plane. A bit mask then limits the write so that only chosen pixel bits change. For each host read it returns one byte, either the raw byte of one plane or a per-pixel colour match across the planes. The read also loads the four plane bytes into the latches, so a later write can reuse them.

The block takes the four plane bytes at the read location as input and drives the four bytes for a write as output. Which planes actually get written, and how host addresses map to plane addresses, is handled elsewhere. All results are registered: each output appears one clock after its strobe and comes with a one-cycle valid pulse.

Top module: `pgd_planar_dp`

## Requirements
- R1: After reset, `plane_wdata`, `host_rdata` and all four latches are zero, and both valid outputs are low.
- R2: The host byte is rotated right by `rot_amt` bit positions before it is used in write modes 0 and 3.
- R3: In write modes 0, 2 and 3 the per-plane source byte is combined with that plane's latch as selected by `alu_fn`: 0 passes the source, 1 ANDs, 2 ORs, 3 XORs.
- R4: Write mode 0 (`wr_mode`=0) uses the rotated host byte as the source of each plane, except that a plane n with `sr_enable[n]`=1 uses `sr_value[n]` copied into all 8 bits.
- R5: Write mode 1 writes each plane's latch unchanged, whatever the host byte, `alu_fn` and `bit_mask` are.
- R6: Write mode 2 uses host data bit n copied into all 8 bits as the source of plane n.
- R7: Write mode 3 uses `sr_value[n]` copied into all 8 bits as the source of plane n, whatever `sr_enable` is. The effective mask is the rotated host byte ANDed with `bit_mask`.
- R8: In modes 0, 2 and 3, a bit position whose effective mask bit is 0 takes the latch bit; a 1 takes the function result.
- R9: Read mode 0 (`cmp_mode`=0) returns byte `rd_plane` of `plane_rdata`. Plane n sits in bits [8n+7:8n] of every 32-bit plane bus.
- R10: Read mode 1 returns, in each bit position, 1 if every plane n with `cmp_care[n]`=1 holds the bit value `cmp_color[n]` there. If no plane is cared for, every bit is 1.
- R11: Every read, in either read mode, loads `plane_rdata` into the latches. A write in the same cycle as a read uses the latch values from before that read.
- R12: `plane_wdata` and `host_rdata` are updated on the clock edge that samples their strobe. `plane_wvalid` and `host_rvalid` are high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe |
| plane_rdata | input | 32 | Four plane bytes at the read location |
| sr_value | input | 4 | Per-plane fill bit |
| sr_enable | input | 4 | Per-plane fill substitution in write mode 0 |
| rot_amt | input | 3 | Right-rotate amount for the host byte |
| alu_fn | input | 2 | Latch combine function |
| bit_mask | input | 8 | Bit-change mask |
| wr_mode | input | 2 | Write mode 0..3 |
| cmp_mode | input | 1 | Read mode: 0 plane byte, 1 colour compare |
| rd_plane | input | 2 | Plane returned in read mode 0 |
| cmp_color | input | 4 | Per-plane compare colour bit |
| cmp_care | input | 4 | Per-plane include-in-compare bit |
| plane_wdata | output | 32 | Four plane bytes for the write |
| plane_wvalid | output | 1 | Write result valid |
| host_rdata | output | 8 | Read result byte |
| host_rvalid | output | 1 | Read result valid |

## Verification
The hardest case to reach is a write whose result depends on the latch, because the latch can only be loaded through a read. Each write vector is therefore preceded by a read that loads a chosen latch pattern. Distinct latch bytes are chosen per plane, so a lane swap or a wrong combine function shows up in the expected bytes. The other hard case is a read and a write strobed in the same cycle. A directed sequence loads one latch value, strobes both with a second value on the plane bus, and uses mode 1 writes to make the old and new latch contents visible at the output.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    localparam int PLANES  = 4;
    localparam int DW      = 8;
    localparam int ROT_W   = $clog2(DW);
    localparam int PSEL_W  = $clog2(PLANES);
    localparam int BUS_W   = PLANES * DW;

    typedef enum logic [1:0] {
        WM_ROTATE = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_FILL   = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } alu_e;

    typedef struct packed {
        logic [BUS_W-1:0] wr_bytes;
        logic             wr_vld;
        logic [DW-1:0]    rd_byte;
        logic             rd_vld;
        logic [BUS_W-1:0] latch;
    } pgd_state_t;
endpackage

// File: rtl/pgd_rotr.sv
module pgd_rotr #(
    parameter int DW    = 8,
    parameter int ROT_W = $clog2(DW)
) (
    input  logic [DW-1:0]    din,
    input  logic [ROT_W-1:0] amt,
    output logic [DW-1:0]    dout
);
    localparam int DBL = 2 * DW;
    logic [DBL-1:0] doubled;

    always_comb begin
        doubled = {din, din} >> amt;
        dout    = doubled[DW-1:0];
    end
endmodule

// File: rtl/pgd_lane.sv
module pgd_lane #(
    parameter int DW = 8
) (
    input  pgd_pkg::wmode_e mode,
    input  pgd_pkg::alu_e   fn,
    input  logic            fill_en,
    input  logic            fill_bit,
    input  logic            host_bit,
    input  logic [DW-1:0]   rot_data,
    input  logic [DW-1:0]   mask,
    input  logic [DW-1:0]   latch,
    output logic [DW-1:0]   dout
);
    import pgd_pkg::*;

    logic [DW-1:0] src;
    logic [DW-1:0] eff_mask;
    logic [DW-1:0] alu_out;

    always_comb begin
        src      = rot_data;
        eff_mask = mask;
        unique case (mode)
            WM_ROTATE: src = fill_en ? {DW{fill_bit}} : rot_data;
            WM_LATCH:  src = latch;
            WM_SPREAD: src = {DW{host_bit}};
            WM_FILL: begin
                src      = {DW{fill_bit}};
                eff_mask = rot_data & mask;
            end
            default:   src = rot_data;
        endcase

        unique case (fn)
            FN_PASS: alu_out = src;
            FN_AND:  alu_out = src & latch;
            FN_OR:   alu_out = src | latch;
            FN_XOR:  alu_out = src ^ latch;
            default: alu_out = src;
        endcase

        if (mode == WM_LATCH) begin
            dout = latch;
        end else begin
            dout = (alu_out & eff_mask) | (latch & ~eff_mask);
        end
    end
endmodule

// File: rtl/pgd_cmp.sv
module pgd_cmp #(
    parameter int DW     = 8,
    parameter int PLANES = 4
) (
    input  logic [PLANES*DW-1:0] planes,
    input  logic [PLANES-1:0]    color,
    input  logic [PLANES-1:0]    care,
    output logic [DW-1:0]        match
);
    logic [PLANES-1:0] hit [DW];

    for (genvar b = 0; b < DW; b++) begin : g_bit
        for (genvar p = 0; p < PLANES; p++) begin : g_plane
            assign hit[b][p] = ~care[p] | (planes[p*DW + b] ~^ color[p]);
        end
        assign match[b] = &hit[b];
    end
endmodule

// File: rtl/pgd_planar_dp.sv
module pgd_planar_dp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  host_wdata,
    input  logic        rd_en,
    input  logic [31:0] plane_rdata,
    input  logic [3:0]  sr_value,
    input  logic [3:0]  sr_enable,
    input  logic [2:0]  rot_amt,
    input  logic [1:0]  alu_fn,
    input  logic [7:0]  bit_mask,
    input  logic [1:0]  wr_mode,
    input  logic        cmp_mode,
    input  logic [1:0]  rd_plane,
    input  logic [3:0]  cmp_color,
    input  logic [3:0]  cmp_care,
    output logic [31:0] plane_wdata,
    output logic        plane_wvalid,
    output logic [7:0]  host_rdata,
    output logic        host_rvalid
);
    import pgd_pkg::*;

    pgd_state_t      st_d, st_q;
    logic [DW-1:0]   rot_data;
    logic [BUS_W-1:0] lane_bus;
    logic [DW-1:0]   cmp_byte;
    logic [DW-1:0]   sel_byte;

    pgd_rotr #(.DW(DW), .ROT_W(ROT_W)) u_rot (
        .din  (host_wdata),
        .amt  (rot_amt),
        .dout (rot_data)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        pgd_lane #(.DW(DW)) u_lane (
            .mode     (wmode_e'(wr_mode)),
            .fn       (alu_e'(alu_fn)),
            .fill_en  (sr_enable[p]),
            .fill_bit (sr_value[p]),
            .host_bit (host_wdata[p]),
            .rot_data (rot_data),
            .mask     (bit_mask),
            .latch    (st_q.latch[p*DW +: DW]),
            .dout     (lane_bus[p*DW +: DW])
        );
    end

    pgd_cmp #(.DW(DW), .PLANES(PLANES)) u_cmp (
        .planes (plane_rdata),
        .color  (cmp_color),
        .care   (cmp_care),
        .match  (cmp_byte)
    );

    always_comb begin
        sel_byte = plane_rdata[rd_plane*DW +: DW];
        st_d        = st_q;
        st_d.wr_vld = wr_en;
        st_d.rd_vld = rd_en;
        if (wr_en) begin
            st_d.wr_bytes = lane_bus;
        end
        if (rd_en) begin
            st_d.rd_byte = cmp_mode ? cmp_byte : sel_byte;
            st_d.latch   = plane_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign plane_wdata  = st_q.wr_bytes;
    assign plane_wvalid = st_q.wr_vld;
    assign host_rdata   = st_q.rd_byte;
    assign host_rvalid  = st_q.rd_vld;
endmodule

// File: rtl/pgd_checker.sv
module pgd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] plane_rdata,
    input logic [7:0]  bit_mask,
    input logic [1:0]  wr_mode,
    input logic        cmp_mode,
    input logic [1:0]  rd_plane,
    input logic [3:0]  cmp_care,
    input logic [31:0] plane_wdata,
    input logic        plane_wvalid,
    input logic [7:0]  host_rdata,
    input logic        host_rvalid
);
    logic [31:0] shadow_q;
    logic [31:0] mask_rep;
    logic [7:0]  pick;

    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else if (rd_en) shadow_q <= plane_rdata;
    end

    assign mask_rep = {4{bit_mask}};
    assign pick     = plane_rdata[rd_plane*8 +: 8];

    p_wvalid_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> plane_wvalid);
    p_wvalid_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !plane_wvalid);
    p_rvalid_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> host_rvalid);
    p_latch_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd1) |=> plane_wdata == $past(shadow_q));
    p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode != 2'd3)
        |=> ((plane_wdata ^ $past(shadow_q)) & ~$past(mask_rep)) == 32'h0);
    p_plane_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cmp_mode) |=> host_rdata == $past(pick));
    p_nocare_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cmp_mode && cmp_care == 4'h0) |=> host_rdata == 8'hFF);
endmodule

bind pgd_planar_dp pgd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .plane_rdata  (plane_rdata),
    .bit_mask     (bit_mask),
    .wr_mode      (wr_mode),
    .cmp_mode     (cmp_mode),
    .rd_plane     (rd_plane),
    .cmp_care     (cmp_care),
    .plane_wdata  (plane_wdata),
    .plane_wvalid (plane_wvalid),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid)
);

// File: tb/sim_pgd_planar_dp.sv
module sim_pgd_planar_dp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] plane_rdata = '0;
    logic [3:0]  sr_value = '0;
    logic [3:0]  sr_enable = '0;
    logic [2:0]  rot_amt = '0;
    logic [1:0]  alu_fn = '0;
    logic [7:0]  bit_mask = 8'hFF;
    logic [1:0]  wr_mode = '0;
    logic        cmp_mode = 1'b0;
    logic [1:0]  rd_plane = '0;
    logic [3:0]  cmp_color = '0;
    logic [3:0]  cmp_care = '0;
    logic [31:0] plane_wdata;
    logic        plane_wvalid;
    logic [7:0]  host_rdata;
    logic        host_rvalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pgd_planar_dp u0 (.*);

    typedef struct packed {
        logic [31:0] latch;
        logic [1:0]  wm;
        logic [1:0]  fn;
        logic [2:0]  rot;
        logic [3:0]  sre;
        logic [3:0]  sr;
        logic [7:0]  mask;
        logic [7:0]  data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h00000000, 2'd0, 2'd0, 3'd3, 4'h0, 4'h0, 8'hFF, 8'h81, 32'h30303030}, // R2
        '{32'h0FF0AA55, 2'd0, 2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h3C, 32'h0C302814}, // R3 AND
        '{32'h0FF0AA55, 2'd0, 2'd2, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h3C, 32'h3FFCBE7D}, // R3 OR
        '{32'h0FF0AA55, 2'd0, 2'd3, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h3C, 32'h33CC9669}, // R3 XOR
        '{32'h00000000, 2'd0, 2'd0, 3'd0, 4'h5, 4'h1, 8'hFF, 8'h5A, 32'h5A005AFF}, // R4
        '{32'h11223344, 2'd1, 2'd3, 3'd0, 4'h0, 4'h0, 8'h00, 8'hFF, 32'h11223344}, // R5
        '{32'h00000000, 2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h06, 32'h00FFFF00}, // R6
        '{32'hAAAAAAAA, 2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'h0F, 8'h0F, 32'hAFAFAFAF}, // R8
        '{32'h00000000, 2'd3, 2'd0, 3'd4, 4'h0, 4'hA, 8'h3C, 8'hF0, 32'h0C000C00}, // R7
        '{32'hF0F0F0F0, 2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'h3C, 8'h0F, 32'hCCCCCCCC}  // R8
    };
    localparam string VREQ [NV] = '{"R2", "R3", "R3", "R3", "R4", "R5", "R6", "R8", "R7", "R8"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [31:0] planes, input logic mode,
                           input logic [1:0] sel, input logic [3:0] col, input logic [3:0] care);
        plane_rdata = planes; cmp_mode = mode; rd_plane = sel;
        cmp_color = col; cmp_care = care; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] wm, input logic [1:0] fn, input logic [2:0] rot,
                            input logic [3:0] sre, input logic [3:0] sr,
                            input logic [7:0] mask, input logic [7:0] data);
        wr_mode = wm; alu_fn = fn; rot_amt = rot; sr_enable = sre;
        sr_value = sr; bit_mask = mask; host_wdata = data; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {plane_wvalid, host_rvalid, 22'd0, host_rdata}, 32'h0);
        check("R1", plane_wdata, 32'h0);
        rst_n = 1'b1;
        step();
        do_write(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h00);
        check("R1 latch", plane_wdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i].latch, 1'b0, 2'd0, 4'h0, 4'h0);
            do_write(VEC[i].wm, VEC[i].fn, VEC[i].rot, VEC[i].sre, VEC[i].sr,
                     VEC[i].mask, VEC[i].data);
            check(VREQ[i], plane_wdata, VEC[i].exp);
        end

        // R12: valid pulse width and timing
        wr_en = 1'b1; wr_mode = 2'd2; alu_fn = 2'd0; bit_mask = 8'hFF; host_wdata = 8'h01;
        step();
        wr_en = 1'b0;
        check("R12 wvalid", {31'd0, plane_wvalid}, 32'h1);
        check("R12 data", plane_wdata, 32'h000000FF);
        step();
        check("R12 wvalid low", {31'd0, plane_wvalid}, 32'h0);

        // R9: plane select in read mode 0
        for (int p = 0; p < 4; p++) begin
            do_read(32'h44332211, 1'b0, 2'(p), 4'h0, 4'h0);
            check("R9", {23'd0, host_rvalid, host_rdata}, {23'd0, 1'b1, 8'(8'h11 * (p + 1))});
        end
        step();
        check("R12 rvalid low", {31'd0, host_rvalid}, 32'h0);

        // R10: colour compare
        do_read(32'h00AACCF0, 1'b1, 2'd0, 4'h3, 4'hF);
        check("R10 all", {24'd0, host_rdata}, 32'h40);
        do_read(32'h00AACCF0, 1'b1, 2'd0, 4'h3, 4'h3);
        check("R10 partial", {24'd0, host_rdata}, 32'hC0);
        do_read(32'h00AACCF0, 1'b1, 2'd0, 4'h3, 4'h0);
        check("R10 none", {24'd0, host_rdata}, 32'hFF);

        // R11: latch loaded by mode-1 read
        do_write(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h00);
        check("R11 cmp-read load", plane_wdata, 32'h00AACCF0);

        // R11: simultaneous read and write uses old latch
        do_read(32'h12345678, 1'b0, 2'd0, 4'h0, 4'h0);
        plane_rdata = 32'h9ABCDEF0; rd_en = 1'b1;
        wr_mode = 2'd1; wr_en = 1'b1;
        step();
        rd_en = 1'b0; wr_en = 1'b0;
        check("R11 old latch", plane_wdata, 32'h12345678);
        do_write(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h00);
        check("R11 new latch", plane_wdata, 32'h9ABCDEF0);

        // R7: enable bits ignored in mode 3
        do_read(32'h00000000, 1'b0, 2'd0, 4'h0, 4'h0);
        do_write(2'd3, 2'd0, 3'd0, 4'hF, 4'h5, 8'hFF, 8'hFF);
        check("R7 enable ignored", plane_wdata, 32'h00FF00FF);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule